// File: doc/BRIEF.md
# External Interrupt Request Controller

This block collects the external interrupt pins of a processor subsystem. There is one non-maskable pin and six maskable request pins, numbered 0 to 5. Every pin passes through a two-stage synchronizer. For each maskable pin, software picks one of four trigger conditions: low level, falling edge, rising edge, or both edges. When the chosen condition is seen, the pin's status flag is set. Software clears that flag by writing to the status register.

A flag reaches the processor only while the matching enable bit is set. Among the enabled pending pins, a programmable 3-bit level decides which one is reported. The winner's vector number goes out on a request/vector interface. The non-maskable pin triggers on the edge that software selects. It ignores every enable and level, always wins, and is cleared by a processor acknowledge. A simple register bus gives access to every control field. Writes on this bus take effect at the clock edge, and reads are combinational.

Top module: `xirq_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0 and `int_req` and `int_vec` are 0. Register addresses: 0 trigger select, 1 enable, 2 status, 3 level, 4 config.
- R2: Trigger code 00 (low level) sets the pin's flag on every cycle in which the synchronized pin is low. A clear written while the pin stays low therefore leaves the flag reading 1.
- R3: Trigger code 01 sets the flag on a high-to-low transition only. Holding the pin low or returning it high sets nothing. Pin n's trigger code sits at bits [2n+1:2n] of register 0.
- R4: Trigger code 10 sets the flag on a low-to-high transition only.
- R5: Trigger code 11 sets the flag on either transition.
- R6: Writing 0 to a status bit (register 2, bit n = pin n) clears it, and writing 1 leaves it unchanged. When a trigger event and a clear of the same bit land on one clock edge, the bit ends up set.
- R7: A pin's flag is set whether or not the pin is enabled. A maskable request reaches `int_req` only when both its flag and its enable bit (register 1, bit n) are 1.
- R8: Among enabled pending pins, the one with the highest level wins (register 3, bits [3n+2:3n]). On equal levels the lower pin number wins. Pin n reports vector 16+n. With no request, `int_vec` is 0.
- R9: Config bit 0 selects the non-maskable edge: 0 (the reset value) for high-to-low, 1 for low-to-high. The other edge sets nothing.
- R10: A pending non-maskable request drives `int_req` with vector 7, regardless of the enable bits and any maskable request. It stays pending until `int_ack` is high on a clock edge.
- R11: A pin change driven before clock edge k first shows in the status register after edge k+2, and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin (asynchronous) |
| irq_pin | input | N_IRQ | Maskable request pins (asynchronous), bit n = pin n |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | N_IRQ*PRIO_W | Write data |
| bus_rdata | output | N_IRQ*PRIO_W | Read data for `bus_addr` (combinational) |
| int_ack | input | 1 | Processor acknowledge; clears a pending non-maskable request |
| int_req | output | 1 | Interrupt request to the processor |
| int_vec | output | 8 | Vector number of the presented request, 0 when idle |

## Verification
The bench places a software clear on the exact edge where an edge event lands. A design that let the clear win would drop that interrupt. It holds a level-triggered pin low while clearing, which catches a design that loses the level condition. It times the synchronizer delay to the edge, so an extra or a missing register stage is reported.

The stimulus table covers equal levels, disabled winners and the idle vector, which exposes arbiters that favour the higher pin or ignore the enable. The non-maskable tests check both edge selections and the unselected edge. They also check that a pending non-maskable request keeps a higher-level maskable one hidden until it is acknowledged.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int N_IRQ_DEF    = 6;
    localparam int PRIO_W_DEF   = 3;
    localparam int VEC_W        = 8;
    localparam int NMI_VEC      = 7;
    localparam int IRQ_VEC_BASE = 16;
    localparam int ADDR_W       = 3;

    localparam logic [ADDR_W-1:0] ADR_SENSE  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_ENABLE = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_LEVEL  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CONFIG = 3'd4;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_BOTH = 2'b11
    } trig_e;

    // Decide whether a synchronized pin sample meets its trigger condition.
    function automatic logic trig_hit(input logic [1:0] mode, input logic cur, input logic prv);
        logic hit;
        case (trig_e'(mode))
            TRIG_LOW:  hit = ~cur;
            TRIG_FALL: hit = prv & ~cur;
            TRIG_RISE: hit = ~prv & cur;
            default:   hit = prv ^ cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= {W{RST_VAL}};
            sync_q <= {W{RST_VAL}};
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
    import xirq_pkg::*;
#(
    parameter int N = N_IRQ_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     pin_s,
    input  logic [N-1:0][1:0] trig,
    input  logic [N-1:0]     clr,
    output logic [N-1:0]     flag,
    output logic [N-1:0]     set_ev
);
    logic [N-1:0] prev_q;
    logic [N-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= pin_s;
    end

    for (genvar n = 0; n < N; n++) begin : g_pin
        assign set_ev[n] = trig_hit(trig[n], pin_s[n], prev_q[n]);

        // A detection event overrides a clear on the same edge.
        always_ff @(posedge clk) begin
            if (rst) flag_q[n] <= 1'b0;
            else     flag_q[n] <= set_ev[n] | (flag_q[n] & ~clr[n]);
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/xirq_arbiter.sv
module xirq_arbiter
    import xirq_pkg::*;
#(
    parameter int N      = N_IRQ_DEF,
    parameter int PRIO_W = PRIO_W_DEF
) (
    input  logic [N-1:0]             active,
    input  logic [N-1:0][PRIO_W-1:0] level,
    output logic                     hit,
    output logic [VEC_W-1:0]         vec
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_lvl;

    // Walk upward; strict compare keeps the lower index on a tie.
    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < N; i++) begin
            if (active[i] && (!hit || level[i] > win_lvl)) begin
                hit     = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = level[i];
            end
        end
    end

    assign vec = hit ? VEC_W'(IRQ_VEC_BASE + int'(win_idx)) : '0;
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter  int N_IRQ  = N_IRQ_DEF,
    parameter  int PRIO_W = PRIO_W_DEF,
    localparam int DW     = N_IRQ * PRIO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_pin,
    input  logic [N_IRQ-1:0]  irq_pin,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              int_ack,
    output logic              int_req,
    output logic [VEC_W-1:0]  int_vec
);
    logic [N_IRQ-1:0][1:0]        trig_q;
    logic [N_IRQ-1:0]             enable_q;
    logic [N_IRQ-1:0][PRIO_W-1:0] level_q;
    logic                         nmi_rise_sel_q;

    logic [N_IRQ:0]   pins_s;
    logic [N_IRQ-1:0] irq_s;
    logic             nmi_s;
    logic             nmi_prev_q;
    logic             nmi_ev;
    logic             nmi_pend;

    logic [N_IRQ-1:0] status;
    logic [N_IRQ-1:0] set_ev;
    logic [N_IRQ-1:0] clr_mask;

    logic             arb_hit;
    logic [VEC_W-1:0] arb_vec;

    xirq_sync #(.W(N_IRQ + 1), .RST_VAL(1'b1)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({nmi_pin, irq_pin}),
        .sync_out (pins_s)
    );
    assign irq_s = pins_s[N_IRQ-1:0];
    assign nmi_s = pins_s[N_IRQ];

    // Register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q         <= '0;
            enable_q       <= '0;
            level_q        <= '0;
            nmi_rise_sel_q <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADR_SENSE:  trig_q         <= bus_wdata[2*N_IRQ-1:0];
                ADR_ENABLE: enable_q       <= bus_wdata[N_IRQ-1:0];
                ADR_LEVEL:  level_q        <= bus_wdata;
                ADR_CONFIG: nmi_rise_sel_q <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    assign clr_mask = (bus_wr && bus_addr == ADR_STATUS) ? ~bus_wdata[N_IRQ-1:0] : '0;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_SENSE:  bus_rdata[2*N_IRQ-1:0] = trig_q;
            ADR_ENABLE: bus_rdata[N_IRQ-1:0]   = enable_q;
            ADR_STATUS: bus_rdata[N_IRQ-1:0]   = status;
            ADR_LEVEL:  bus_rdata              = level_q;
            ADR_CONFIG: bus_rdata[0]           = nmi_rise_sel_q;
            default:    bus_rdata              = '0;
        endcase
    end

    xirq_detect #(.N(N_IRQ)) u_detect (
        .clk    (clk),
        .rst    (rst),
        .pin_s  (irq_s),
        .trig   (trig_q),
        .clr    (clr_mask),
        .flag   (status),
        .set_ev (set_ev)
    );

    // Non-maskable pin: selected edge only, cleared by acknowledge.
    assign nmi_ev = trig_hit(nmi_rise_sel_q ? TRIG_RISE : TRIG_FALL, nmi_s, nmi_prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev_q <= 1'b1;
            nmi_pend   <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_s;
            nmi_pend   <= nmi_ev | (nmi_pend & ~int_ack);
        end
    end

    xirq_arbiter #(.N(N_IRQ), .PRIO_W(PRIO_W)) u_arb (
        .active (status & enable_q),
        .level  (level_q),
        .hit    (arb_hit),
        .vec    (arb_vec)
    );

    assign int_req = nmi_pend | arb_hit;
    assign int_vec = nmi_pend ? VEC_W'(NMI_VEC) : arb_vec;
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk
    import xirq_pkg::*;
#(
    parameter int N_IRQ = N_IRQ_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic             int_req,
    input logic [VEC_W-1:0] int_vec,
    input logic             int_ack,
    input logic             nmi_pend,
    input logic [N_IRQ-1:0] status,
    input logic [N_IRQ-1:0] enable_q,
    input logic [N_IRQ-1:0] set_ev
);
    // R7: a maskable request needs a flag that is also enabled
    a_r7_req_gated: assert property (@(posedge clk) disable iff (rst)
        (int_req && !nmi_pend) |-> ((status & enable_q) != '0));

    // R8: maskable vectors stay inside the pin range
    a_r8_vec_range: assert property (@(posedge clk) disable iff (rst)
        (int_req && !nmi_pend) |->
            (int'(int_vec) >= IRQ_VEC_BASE && int'(int_vec) < IRQ_VEC_BASE + N_IRQ));

    // R10: a pending non-maskable request is always presented with vector 7
    a_r10_nmi_first: assert property (@(posedge clk) disable iff (rst)
        nmi_pend |-> (int_req && int_vec == VEC_W'(NMI_VEC)));

    // R10: only an acknowledge retires the non-maskable request
    a_r10_nmi_hold: assert property (@(posedge clk) disable iff (rst)
        (nmi_pend && !int_ack) |=> nmi_pend);

    // R6: a detection event always leaves its flag set
    a_r6_set_sticks: assert property (@(posedge clk) disable iff (rst)
        (set_ev != '0) |=> ((status & $past(set_ev)) == $past(set_ev)));

    // R11: no flag rises without a detection event on the previous cycle
    a_r11_rise_cause: assert property (@(posedge clk) disable iff (rst)
        ((status & ~$past(status) & ~$past(set_ev)) == '0));
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .int_req  (int_req),
    .int_vec  (int_vec),
    .int_ack  (int_ack),
    .nmi_pend (nmi_pend),
    .status   (status),
    .enable_q (enable_q),
    .set_ev   (set_ev)
);

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb;
    localparam int N  = 6;
    localparam int PW = 3;
    localparam int DW = N * PW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          nmi_pin = 1'b1;
    logic [N-1:0]  irq_pin = '1;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          int_ack = 1'b0;
    logic          int_req;
    logic [7:0]    int_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xirq_ctrl #(.N_IRQ(N), .PRIO_W(PW)) u_dut (
        .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .irq_pin(irq_pin),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .int_ack(int_ack), .int_req(int_req), .int_vec(int_vec)
    );

    typedef struct packed {
        logic [N-1:0]         en;
        logic [N-1:0][PW-1:0] lvl;
        logic [N-1:0]         low;
        logic                 req;
        logic [7:0]           vec;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TABLE [NV] = '{
        '{6'h3F, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 6'b000110, 1'b1, 8'd17},
        '{6'h3F, {3'd7,3'd0,3'd0,3'd0,3'd0,3'd0}, 6'b100001, 1'b1, 8'd21},
        '{6'h3F, {3'd0,3'd5,3'd0,3'd5,3'd0,3'd0}, 6'b010100, 1'b1, 8'd18},
        '{6'h1F, {3'd7,3'd0,3'd0,3'd0,3'd0,3'd1}, 6'b100001, 1'b1, 8'd16},
        '{6'h00, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 6'b111111, 1'b0, 8'd0},
        '{6'h08, {3'd0,3'd0,3'd3,3'd0,3'd6,3'd0}, 6'b001010, 1'b1, 8'd19},
        '{6'h3F, {3'd6,3'd7,3'd4,3'd3,3'd2,3'd1}, 6'b111111, 1'b1, 8'd20}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R1 register reset", 32'(d), 0);
        end
        chk("R1 int_req reset", 32'(int_req), 0);
        chk("R1 int_vec reset", 32'(int_vec), 0);

        // R7 / R8: table walk with level-triggered pins held low
        for (int i = 0; i < NV; i++) begin
            wr(3'd3, TABLE[i].lvl);
            wr(3'd1, 18'(TABLE[i].en));
            irq_pin = ~TABLE[i].low;
            wait_n(4);
            chk($sformatf("R8 req entry %0d", i), 32'(int_req), 32'(TABLE[i].req));
            chk($sformatf("R8 vec entry %0d", i), 32'(int_vec), 32'(TABLE[i].vec));
            rd(3'd2, d);
            chk($sformatf("R7 status entry %0d", i), 32'(d), 32'(TABLE[i].low));
            irq_pin = '1;
            wait_n(4);
            wr(3'd2, '0);
            rd(3'd2, d);
            chk($sformatf("R6 clear entry %0d", i), 32'(d), 0);
        end

        // Trigger codes: pin0 fall, pin1 rise, pin2 both, pin3 low, pin4 fall
        wr(3'd3, '0);
        wr(3'd0, 18'h139);
        rd(3'd0, d);
        chk("R3 trigger readback", 32'(d), 32'h139);
        wr(3'd1, 18'h3F);

        // R11 latency and R3 falling edge
        @(negedge clk); irq_pin[0] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(3'd2, d);
        chk("R11 not after k+1", 32'(d), 0);
        @(posedge clk); @(negedge clk);
        rd(3'd2, d);
        chk("R11 set after k+2", 32'(d), 1);
        chk("R3 req", 32'(int_req), 1);
        chk("R3 vec", 32'(int_vec), 16);
        wr(3'd2, 18'h3E);
        rd(3'd2, d);
        chk("R3 held low no re-set", 32'(d), 0);
        irq_pin[0] = 1'b1; wait_n(4);
        rd(3'd2, d);
        chk("R3 rise ignored", 32'(d), 0);

        // R4 rising edge
        irq_pin[1] = 1'b0; wait_n(4);
        rd(3'd2, d);
        chk("R4 fall ignored", 32'(d), 0);
        irq_pin[1] = 1'b1; wait_n(4);
        rd(3'd2, d);
        chk("R4 rise sets", 32'(d), 2);
        wr(3'd2, 18'h3F);
        rd(3'd2, d);
        chk("R6 write one keeps", 32'(d), 2);
        wr(3'd2, '0);

        // R5 both edges
        irq_pin[2] = 1'b0; wait_n(4);
        rd(3'd2, d);
        chk("R5 fall sets", 32'(d), 4);
        wr(3'd2, '0);
        irq_pin[2] = 1'b1; wait_n(4);
        rd(3'd2, d);
        chk("R5 rise sets", 32'(d), 4);
        wr(3'd2, '0);

        // R2 low level
        irq_pin[3] = 1'b0; wait_n(4);
        wr(3'd2, '0);
        rd(3'd2, d);
        chk("R2 clear while low", 32'(d), 8);
        irq_pin[3] = 1'b1; wait_n(4);
        wr(3'd2, '0);
        rd(3'd2, d);
        chk("R2 clear after release", 32'(d), 0);

        // R6 event and clear on the same edge
        @(negedge clk); irq_pin[4] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = '0;
        @(negedge clk); bus_wr = 1'b0;
        rd(3'd2, d);
        chk("R6 set wins", 32'(d), 32'h10);
        irq_pin[4] = 1'b1; wait_n(4);
        wr(3'd2, '0);

        // R10 non-maskable, falling by default, over a level-7 request
        wr(3'd1, 18'h20);
        wr(3'd3, {3'd7, 15'd0});
        wr(3'd0, '0);
        irq_pin[5] = 1'b0;
        nmi_pin = 1'b0;
        wait_n(4);
        chk("R10 req", 32'(int_req), 1);
        chk("R10 vec over level 7", 32'(int_vec), 7);
        wait_n(3);
        chk("R10 stays pending", 32'(int_vec), 7);
        int_ack = 1'b1; @(negedge clk); int_ack = 1'b0;
        chk("R10 ack reveals pin5", 32'(int_vec), 21);
        irq_pin[5] = 1'b1; wait_n(4);
        wr(3'd2, '0);
        wr(3'd1, '0);
        chk("R10 idle after ack", 32'(int_req), 0);

        // R9 rising selection
        wr(3'd4, 18'h1);
        rd(3'd4, d);
        chk("R9 config readback", 32'(d), 1);
        nmi_pin = 1'b1; wait_n(4);
        chk("R9 rise sets", 32'(int_vec), 7);
        int_ack = 1'b1; @(negedge clk); int_ack = 1'b0;
        nmi_pin = 1'b0; wait_n(4);
        chk("R9 fall ignored", 32'(int_req), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule